// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block turns one burst request into the column addresses that the burst visits, one address per beat. A request carries a starting column, a burst length of four or eight beats and an ordering choice (sequential or interleaved). The first address leaves the block on the cycle after the request is taken. Every beat comes with a valid flag, and the opening and closing beats are marked. A memory controller uses it to step data beats through the column space of an open row.

All beats of a burst stay inside an aligned window of columns whose size equals the burst length. The bits above that window never change; only the low two or three bits move. Sequential order of an eight-beat burst walks the starting four-column half first and then the other half, each half counted upward with wrap. Interleaved order is the starting low bits exclusive-ored with the beat number. The block serves one burst at a time and turns away any request that arrives while a burst is running.

Top module: `colseq_top`

## Requirements
- R1: A request with `start_i` high while `busy_o` is low is accepted at that clock edge. The first beat then shows on the next cycle with `valid_o` and `first_o` high. `first_o` is high on no other beat.
- R2: A burst with `bl8_i`=0 has exactly 4 valid beats and one with `bl8_i`=1 has exactly 8. `last_o` is high on the final beat only, and the beats follow each other in back-to-back cycles.
- R3: On every beat, column bits 3 and up equal those of the start column. For a four-beat burst, bit 2 is also held at its start value.
- R4: Sequential (`ilv_i`=0), four beats: beat i has low bits [1:0] equal to (start[1:0] + i) mod 4.
- R5: Sequential, eight beats: on beats 0 to 3, bit 2 equals start bit 2. On beats 4 to 7, bit 2 is its inverse. On every beat, bits [1:0] are (start[1:0] + i) mod 4.
- R6: Interleaved (`ilv_i`=1): beat i has low bits equal to the start low bits XOR i. That is 2 bits for four-beat bursts and 3 bits for eight-beat bursts.
- R7: A request arriving while `busy_o` is high is ignored. The running burst carries on unchanged and no new burst follows it.
- R8: `busy_o` is high from the cycle of the first beat through the last beat, and low on the cycle after the last beat.
- R9: While reset is held and just after it, `valid_o`, `first_o`, `last_o` and `busy_o` are low.
- R10: Column, length and order are sampled when the request is accepted. Changing `col_i`, `bl8_i` or `ilv_i` during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | 1 = eight beats, 0 = four beats |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| valid_o | output | 1 | A beat address is present |
| col_o | output | COL_W | Column address of the current beat |
| first_o | output | 1 | Current beat is the first of the burst |
| last_o | output | 1 | Current beat is the last of the burst |
| busy_o | output | 1 | A burst is in progress |

## Verification
The refusal of a new request and the stepping of a running burst can meet in the same cycle. The bench raises `start_i` with a different column while the third beat is on the outputs. It then judges through its scoreboard that the remaining beats match the original burst and that no extra beats appear afterwards. The closing of a burst and the idle check meet as well: on the cycle after `last_o`, `busy_o` must already be low. The bench also alters the request inputs during every burst to show they were sampled only at acceptance.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam int unsigned LOW_W = 3;

  typedef struct packed {
    logic bl8;
    logic ilv;
  } burst_cfg_t;

  // Index of the final beat for a given length setting.
  function automatic logic [LOW_W-1:0] final_idx(input logic bl8);
    return bl8 ? 3'd7 : 3'd3;
  endfunction

  // Low column bits of beat idx relative to the starting low bits.
  function automatic logic [LOW_W-1:0] beat_low(input logic [LOW_W-1:0] st,
                                                input logic [LOW_W-1:0] idx,
                                                input burst_cfg_t       cfg);
    logic [1:0] cnt;
    logic       half;
    if (cfg.ilv) begin
      beat_low = st ^ (cfg.bl8 ? idx : {1'b0, idx[1:0]});
    end else begin
      cnt  = st[1:0] + idx[1:0];
      half = st[2] ^ (cfg.bl8 & idx[2]);
      beat_low = {half, cnt};
    end
  endfunction

endpackage

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bl8_i,
  output logic             accept_o,
  output logic             active_o,
  output logic [LOW_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);

  logic             active_q;
  logic [LOW_W-1:0] idx_q;
  logic             bl8_q;
  logic             at_end;

  assign accept_o = start_i & ~active_q;
  assign at_end   = active_q & (idx_q == final_idx(bl8_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      bl8_q    <= 1'b0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      bl8_q    <= bl8_i;
    end else if (at_end) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      idx_q    <= idx_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign first_o  = active_q & (idx_q == '0);
  assign last_o   = at_end;

endmodule

// File: rtl/colseq_order.sv
module colseq_order
  import colseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  burst_cfg_t       cfg_i,
  input  logic [LOW_W-1:0] idx_i,
  output logic [COL_W-1:0] col_o
);

  localparam int unsigned HI_W = COL_W - LOW_W;

  logic [LOW_W-1:0] low;

  always_comb low = beat_low(base_i[LOW_W-1:0], idx_i, cfg_i);

  generate
    if (HI_W > 0) begin : g_hi
      assign col_o = {base_i[COL_W-1:LOW_W], low};
    end else begin : g_lo
      assign col_o = low[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/colseq_top.sv
module colseq_top
  import colseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             ilv_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             first_o,
  output logic             last_o,
  output logic             busy_o
);

  logic             accept;
  logic             active;
  logic [LOW_W-1:0] beat_idx;
  logic [COL_W-1:0] base_q;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] col_raw;

  colseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .bl8_i   (bl8_i),
    .accept_o(accept),
    .active_o(active),
    .idx_o   (beat_idx),
    .first_o (first_o),
    .last_o  (last_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      base_q <= col_i;
      cfg_q  <= '{bl8: bl8_i, ilv: ilv_i};
    end
  end

  colseq_order #(.COL_W(COL_W)) u_order (
    .base_i(base_q),
    .cfg_i (cfg_q),
    .idx_i (beat_idx),
    .col_o (col_raw)
  );

  assign valid_o = active;
  assign busy_o  = active;
  assign col_o   = active ? col_raw : '0;

endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic [2:0]       beat_idx,
  input logic             cfg_bl8,
  input logic             cfg_ilv,
  input logic             valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             first_o,
  input logic             last_o,
  input logic             busy_o
);

  p_first_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (valid_o && first_o));

  p_first_needs_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> $past(accept));

  p_last_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (beat_idx == (cfg_bl8 ? 3'd7 : 3'd3)));

  p_beat_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> (valid_o && !first_o));

  p_upper_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !first_o) |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  p_bl4_bit2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !first_o && !cfg_bl8) |-> (col_o[2] == $past(col_o[2])));

  p_ilv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !first_o && cfg_ilv) |->
      ((col_o[2:0] ^ $past(col_o[2:0])) == (beat_idx ^ $past(beat_idx))));

  p_busy_refuses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept);

  p_last_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_o);

endmodule

bind colseq_top colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (accept),
  .beat_idx(beat_idx),
  .cfg_bl8 (cfg_q.bl8),
  .cfg_ilv (cfg_q.ilv),
  .valid_o (valid_o),
  .col_o   (col_o),
  .first_o (first_o),
  .last_o  (last_o),
  .busy_o  (busy_o)
);

// File: tb/colseq_top_tb_top.sv
module colseq_top_tb_top;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             bl8_i = 1'b0;
  logic             ilv_i = 1'b0;
  logic             valid_o, first_o, last_o, busy_o;
  logic [COL_W-1:0] col_o;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [COL_W-1:0] col;
    bit               first;
    bit               last;
    string            tag;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk = ~clk;

  colseq_top #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .bl8_i(bl8_i), .ilv_i(ilv_i), .valid_o(valid_o), .col_o(col_o),
    .first_o(first_o), .last_o(last_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference: walk the window beat by beat.
  function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] st,
                                               input bit bl8, input bit ilv,
                                               input int i);
    logic [COL_W-1:0] c;
    int win;
    win = bl8 ? 8 : 4;
    c = st;
    if (ilv) begin
      c[2:0] = st[2:0] ^ 3'(i);
    end else if (!bl8) begin
      c[1:0] = 2'((int'(st[1:0]) + i) % 4);   // R4
    end else begin
      c[2]   = (i < 4) ? st[2] : ~st[2];      // R5
      c[1:0] = 2'((int'(st[1:0]) + i) % 4);
    end
    if (win == 4) c[COL_W-1:2] = st[COL_W-1:2]; // R3
    return c;
  endfunction

  task automatic burst(input logic [COL_W-1:0] st, input bit bl8,
                       input bit ilv, input bit poke);
    int n;
    exp_t e;
    n = bl8 ? 8 : 4;
    for (int i = 0; i < n; i++) begin
      e.col   = ref_col(st, bl8, ilv, i);
      e.first = (i == 0);
      e.last  = (i == n - 1);
      e.tag   = ilv ? "R6" : (bl8 ? "R5" : "R4");
      exp_q.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b1; col_i = st; bl8_i = bl8; ilv_i = ilv;
    @(negedge clk);
    // R10: scramble request inputs while the burst runs
    start_i = 1'b0; col_i = ~st; bl8_i = ~bl8; ilv_i = ~ilv;
    if (poke) begin
      // R7: request during third beat must be ignored
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b1; col_i = st ^ 10'h155;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(busy_o == 1'b0 && valid_o == 1'b0, "R8 idle after last beat",
          {30'd0, busy_o, valid_o}, 32'd0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected beat", 32'(col_o), 32'hffff_ffff);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(col_o == e.col, {e.tag, "/R3 column"}, 32'(col_o), 32'(e.col));
        check(first_o == e.first, "R1 first marker", 32'(first_o), 32'(e.first));
        check(last_o == e.last, "R2 last marker", 32'(last_o), 32'(e.last));
        check(busy_o == 1'b1, "R8 busy during beat", 32'(busy_o), 32'd1);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check({valid_o, first_o, last_o, busy_o} == 4'b0, "R9 outputs in reset",
          32'({valid_o, first_o, last_o, busy_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({valid_o, busy_o} == 2'b0, "R9 idle after reset",
          32'({valid_o, busy_o}), 32'd0);
    for (int lo = 0; lo < 8; lo++) begin
      burst(10'h2a8 | 10'(lo), 1'b0, 1'b0, 1'b0);
      burst(10'h150 | 10'(lo), 1'b1, 1'b0, 1'b0);
      burst(10'h3f8 | 10'(lo), 1'b0, 1'b1, 1'b0);
      burst(10'h008 | 10'(lo), 1'b1, 1'b1, 1'b0);
    end
    burst(10'h1f5, 1'b1, 1'b0, 1'b1);
    burst(10'h0c6, 1'b0, 1'b1, 1'b1);
    burst(10'h37b, 1'b1, 1'b1, 1'b1);
    burst(10'h201, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && valid_o == 1'b0, "R2 no trailing beats",
          32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule